// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block sits between the external pins of a parallel NOR flash and its internal sequencer and array. On every clock it registers the active-low select, output-enable, write-enable and hardware-reset pins, plus the width-select pin, the address and the incoming data bus. From the registered pins it works out the bus operation: standby, output off, read, write or hardware reset. The operation is reported to the rest of the chip.

For reads, the block sends the word address and byte lane to the array. It returns the array's 16-bit word on the data bus as a value plus a per-bit drive enable. In byte mode, bit 15 of the data bus is an extra low address input, and only the lower eight pins are driven.

For writes, the block holds the address and data of the write cycle in progress. When the combined select/write strobe is released, it hands them to the sequencer with a one-cycle valid pulse. A low hardware-reset pin blocks every access and drops any write that has not yet completed.

Top module: `fbus_front`

## Requirements
- R1: In word mode (`pin_wide`=1), a read (`pin_cs_n`=0, `pin_oe_n`=0, `pin_we_n`=1, `pin_rst_n`=1) drives `dq_oe`=16'hFFFF and `dq_out`=`arr_rdata`, two clock edges after the pins are applied.
- R2: In byte mode (`pin_wide`=0), `dq_in[15]` is the low address bit and appears on `arr_lane`. A read drives `dq_oe`=16'h00FF. `dq_out[7:0]` carries `arr_rdata[7:0]` when that bit is 0 and `arr_rdata[15:8]` when it is 1, and `dq_out[15:8]` is 0.
- R3: With the chip selected, `pin_oe_n`=1 and `pin_we_n`=1, `bus_op` is 1 (output off) and `dq_oe` is 0.
- R4: With `pin_cs_n`=1, `bus_op` is 0 (standby) and `dq_oe` is 0, whatever the other control pins are.
- R5: A write (`pin_cs_n`=0, `pin_we_n`=0, `pin_oe_n`=1) gives `bus_op`=3 and `dq_oe`=0. After the strobe is released, `cmd_valid` pulses for exactly one cycle, with `cmd_addr` and `cmd_data` equal to the pin values of the last write cycle.
- R6: A write in byte mode presents `cmd_data`={8'h00, `dq_in[7:0]`} and `cmd_lane`=`dq_in[15]`. A write in word mode presents all 16 bits with `cmd_lane`=0.
- R7: While `pin_rst_n`=0, `bus_op` is 4 and `dq_oe` is 0. A write that is in progress when `pin_rst_n` falls never produces `cmd_valid`.
- R8: Read or write attempts made while `pin_rst_n`=0 drive no output and produce no `cmd_valid`.
- R9: `bus_op` follows the pins one clock edge after they are applied, with priority reset > standby > write > read > output off.
- R10: While `rst_n`=0, `bus_op` is 4, `dq_oe` is 0 and `cmd_valid` is 0.
- R11: With `pin_oe_n` and `pin_we_n` both low and the chip selected, the cycle is treated as output off: `bus_op`=1, no drive and no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pin_cs_n | input | 1 | Chip select pin, active low |
| pin_oe_n | input | 1 | Output enable pin, active low |
| pin_we_n | input | 1 | Write enable pin, active low |
| pin_rst_n | input | 1 | Hardware reset pin, active low |
| pin_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| pin_addr | input | ADDR_W | Word address pins |
| dq_in | input | 16 | Data bus input value |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-bit drive enable for the data bus |
| arr_addr | output | ADDR_W | Word address to the array |
| arr_lane | output | 1 | Byte lane in byte mode, 0 in word mode |
| arr_rdata | input | 16 | Word read from the array at `arr_addr` |
| bus_op | output | 3 | Decoded operation: 0 standby, 1 output off, 2 read, 3 write, 4 reset |
| cmd_valid | output | 1 | One-cycle pulse: a write cycle has completed |
| cmd_addr | output | ADDR_W | Word address of the completed write |
| cmd_lane | output | 1 | Byte lane of the completed write |
| cmd_data | output | 16 | Data of the completed write |

## Verification
The hardest case to reach is a write strobe that is still low when the hardware-reset pin falls. The write data has been captured, but the strobe has not yet risen. To get there, the bench holds a write for several cycles and then pulls the reset pin low while write enable stays asserted. It then releases everything together and watches several cycles to confirm that no command pulse appears. The same sequence, run without the reset, serves as the positive case, and it shows that the pulse and its data depend only on the strobe release.

// File: rtl/fbus_pkg.sv
// Shared widths and the bus operation code for the flash bus front end.
package fbus_pkg;
    localparam int DQ_W   = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DQ_W / LANE_W;

    typedef enum logic [2:0] {
        OP_STANDBY = 3'd0,
        OP_OUTOFF  = 3'd1,
        OP_READ    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_RESET   = 3'd4
    } bus_op_t;
endpackage

// File: rtl/fbus_pin_sampler.sv
// Registers every external pin once per clock.
// Assumes the pins are already synchronous to clk or are slow relative to it.
// Under block reset it loads an idle bus held in hardware reset.
module fbus_pin_sampler #(
    parameter int ADDR_W = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n_i,
    input  logic                    oe_n_i,
    input  logic                    we_n_i,
    input  logic                    hrst_n_i,
    input  logic                    wide_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [fbus_pkg::DQ_W-1:0] dq_i,
    output logic                    cs_n_q,
    output logic                    oe_n_q,
    output logic                    we_n_q,
    output logic                    hrst_n_q,
    output logic                    wide_q,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [fbus_pkg::DQ_W-1:0] dq_q
);
    // Capture the pin state; reset to an idle bus held in hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            we_n_q   <= 1'b1;
            hrst_n_q <= 1'b0;
            wide_q   <= 1'b1;
            addr_q   <= '0;
            dq_q     <= '0;
        end else begin
            cs_n_q   <= cs_n_i;
            oe_n_q   <= oe_n_i;
            we_n_q   <= we_n_i;
            hrst_n_q <= hrst_n_i;
            wide_q   <= wide_i;
            addr_q   <= addr_i;
            dq_q     <= dq_i;
        end
    end
endmodule

// File: rtl/fbus_op_decode.sv
// Turns the registered control pins into one bus operation.
// Priority: hardware reset, then standby, then write, then read, else output off.
// Output enable and write enable low together count as output off.
module fbus_op_decode
    import fbus_pkg::*;
(
    input  logic    cs_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    hrst_n,
    output bus_op_t op
);
    // Priority decode of the control pins.
    always_comb begin
        if (!hrst_n)
            op = OP_RESET;
        else if (cs_n)
            op = OP_STANDBY;
        else if (!we_n && oe_n)
            op = OP_WRITE;
        else if (!oe_n && we_n)
            op = OP_READ;
        else
            op = OP_OUTOFF;
    end
endmodule

// File: rtl/fbus_data_steer.sv
// Builds the registered data bus output value and per-bit drive enables.
// In word mode both lanes carry the array word. In byte mode the lane
// picked by the extra low address bit is placed on the lower pins, and the
// upper pins stay undriven. Drive happens only for a read.
module fbus_data_steer
    import fbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  bus_op_t         op,
    input  logic            wide,
    input  logic            lane_sel,
    input  logic [DQ_W-1:0] rdata,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe
);
    logic [DQ_W-1:0]   nxt_out;
    logic [DQ_W-1:0]   nxt_oe;
    logic [LANE_W-1:0] picked;
    logic              is_read;

    assign is_read = (op == OP_READ);

    // Byte selected for an 8-bit access.
    assign picked = lane_sel ? rdata[2*LANE_W-1:LANE_W] : rdata[LANE_W-1:0];

    // Per-lane value and enable; lane 0 is active in both modes, upper lanes only when wide.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign nxt_out[LANE_W-1:0] = !is_read ? '0 :
                                         (wide ? rdata[LANE_W-1:0] : picked);
            assign nxt_oe[LANE_W-1:0]  = {LANE_W{is_read}};
        end else begin : g_high
            assign nxt_out[g*LANE_W +: LANE_W] = (is_read && wide) ?
                                                 rdata[g*LANE_W +: LANE_W] : '0;
            assign nxt_oe[g*LANE_W +: LANE_W]  = {LANE_W{is_read && wide}};
        end
    end

    // Register the bus drive so the pins see clean edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else begin
            dq_out <= nxt_out;
            dq_oe  <= nxt_oe;
        end
    end

    // R2
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 16'h0000) || (dq_oe == 16'h00FF) || (dq_oe == 16'hFFFF));

    // R1
    drive_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0) |-> ($past(op) == OP_READ));
endmodule

// File: rtl/fbus_cmd_latch.sv
// Holds the address and data of a write cycle in progress. When the combined
// select/write strobe is released, it hands them to the sequencer with a
// one-cycle pulse. A hardware reset drops a write that is still pending.
module fbus_cmd_latch
    import fbus_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_t           op,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lane,
    output logic [DQ_W-1:0]   cmd_data
);
    logic              wr_pend;
    logic [ADDR_W-1:0] hold_addr;
    logic              hold_lane;
    logic [DQ_W-1:0]   hold_data;
    logic [DQ_W-1:0]   cap_data;
    logic              cap_lane;

    // Data and lane as seen on the pins for the current bus width.
    assign cap_data = wide ? dq : {{(DQ_W-LANE_W){1'b0}}, dq[LANE_W-1:0]};
    assign cap_lane = !wide && dq[DQ_W-1];

    // Track the write strobe and publish the command on its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pend   <= 1'b0;
            hold_addr <= '0;
            hold_lane <= 1'b0;
            hold_data <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_lane  <= 1'b0;
            cmd_data  <= '0;
        end else if (op == OP_RESET) begin
            wr_pend   <= 1'b0;
            cmd_valid <= 1'b0;
        end else if (op == OP_WRITE) begin
            wr_pend   <= 1'b1;
            hold_addr <= addr;
            hold_lane <= cap_lane;
            hold_data <= cap_data;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= wr_pend;
            wr_pend   <= 1'b0;
            if (wr_pend) begin
                cmd_addr <= hold_addr;
                cmd_lane <= hold_lane;
                cmd_data <= hold_data;
            end
        end
    end

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    no_cmd_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(op) != OP_RESET));
endmodule

// File: rtl/fbus_front.sv
// Top of the parallel flash bus front end. It samples the pins, decodes the
// bus operation, steers read data onto the bus and latches write commands.
// Assumes the pins are driven synchronously to clk; the data bus is split
// into an output value and per-bit drive enables for a pad ring.
module fbus_front
    import fbus_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_cs_n,
    input  logic              pin_oe_n,
    input  logic              pin_we_n,
    input  logic              pin_rst_n,
    input  logic              pin_wide,
    input  logic [ADDR_W-1:0] pin_addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_lane,
    input  logic [15:0]       arr_rdata,
    output logic [2:0]        bus_op,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_lane,
    output logic [15:0]       cmd_data
);
    logic              s_cs_n, s_oe_n, s_we_n, s_hrst_n, s_wide;
    logic [ADDR_W-1:0] s_addr;
    logic [DQ_W-1:0]   s_dq;
    bus_op_t           op;
    logic              lane_sel;

    fbus_pin_sampler #(.ADDR_W(ADDR_W)) u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (pin_cs_n),
        .oe_n_i   (pin_oe_n),
        .we_n_i   (pin_we_n),
        .hrst_n_i (pin_rst_n),
        .wide_i   (pin_wide),
        .addr_i   (pin_addr),
        .dq_i     (dq_in),
        .cs_n_q   (s_cs_n),
        .oe_n_q   (s_oe_n),
        .we_n_q   (s_we_n),
        .hrst_n_q (s_hrst_n),
        .wide_q   (s_wide),
        .addr_q   (s_addr),
        .dq_q     (s_dq)
    );

    fbus_op_decode u_decode (
        .cs_n   (s_cs_n),
        .oe_n   (s_oe_n),
        .we_n   (s_we_n),
        .hrst_n (s_hrst_n),
        .op     (op)
    );

    // The top data pin doubles as the low address bit in byte mode.
    assign lane_sel = !s_wide && s_dq[DQ_W-1];
    assign arr_addr = s_addr;
    assign arr_lane = lane_sel;
    assign bus_op   = op;

    fbus_data_steer u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wide     (s_wide),
        .lane_sel (lane_sel),
        .rdata    (arr_rdata),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    fbus_cmd_latch #(.ADDR_W(ADDR_W)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .wide      (s_wide),
        .addr      (s_addr),
        .dq        (s_dq),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_lane  (cmd_lane),
        .cmd_data  (cmd_data)
    );

    // R7
    rst_pin_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pin_rst_n) |-> (bus_op == 3'd4));

    // R2
    byte_lane_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 16'h00FF) |-> !$past(pin_wide, 2));
endmodule

// File: tb/sim_fbus_front.sv
// Directed bench for fbus_front: one task per scenario, each checking itself.
module sim_fbus_front;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin_cs_n = 1'b1, pin_oe_n = 1'b1, pin_we_n = 1'b1;
    logic          pin_rst_n = 1'b1, pin_wide = 1'b1;
    logic [AW-1:0] pin_addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out, dq_oe, arr_rdata, cmd_data;
    logic [AW-1:0] arr_addr, cmd_addr;
    logic          arr_lane, cmd_valid, cmd_lane;
    logic [2:0]    bus_op;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // Array model: word content derived from its address.
    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hC3A5;
    endfunction
    assign arr_rdata = mem_word(arr_addr);

    fbus_front #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pin_cs_n(pin_cs_n), .pin_oe_n(pin_oe_n), .pin_we_n(pin_we_n),
        .pin_rst_n(pin_rst_n), .pin_wide(pin_wide), .pin_addr(pin_addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .arr_addr(arr_addr), .arr_lane(arr_lane), .arr_rdata(arr_rdata),
        .bus_op(bus_op), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_lane(cmd_lane), .cmd_data(cmd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic cs, input logic oe, input logic we, input logic rp,
                         input logic wide, input logic [AW-1:0] a, input logic [15:0] d);
        pin_cs_n = cs; pin_oe_n = oe; pin_we_n = we; pin_rst_n = rp;
        pin_wide = wide; pin_addr = a; dq_in = d;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmd_valid) cnt++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(2);
        chk("R10 bus_op", 32'(bus_op), 32'd4);
        chk("R10 dq_oe", 32'(dq_oe), 32'd0);
        chk("R10 cmd_valid", 32'(cmd_valid), 32'd0);
        rst_n = 1'b1;
        drive(1, 1, 1, 1, 1, '0, '0);
        wait_cyc(2);
        chk("R4 idle op", 32'(bus_op), 32'd0);
    endtask

    task automatic t_word_read(input logic [AW-1:0] a);
        drive(0, 0, 1, 1, 1, a, 16'h0000);
        wait_cyc(1);
        chk("R9 read op", 32'(bus_op), 32'd2);
        wait_cyc(1);
        chk("R1 word oe", 32'(dq_oe), 32'hFFFF);
        chk("R1 word data", 32'(dq_out), 32'(mem_word(a)));
    endtask

    task automatic t_byte_read(input logic [AW-1:0] a, input logic lane);
        logic [15:0] w;
        w = mem_word(a);
        drive(0, 0, 1, 1, 0, a, {lane, 15'h0});
        wait_cyc(2);
        chk("R2 lane out", 32'(arr_lane), 32'(lane));
        chk("R2 byte oe", 32'(dq_oe), 32'h00FF);
        chk("R2 byte data", 32'(dq_out), lane ? 32'(w[15:8]) : 32'(w[7:0]));
    endtask

    task automatic t_out_off;
        drive(0, 1, 1, 1, 1, 19'h00123, '0);
        wait_cyc(2);
        chk("R3 op", 32'(bus_op), 32'd1);
        chk("R3 oe", 32'(dq_oe), 32'd0);
    endtask

    task automatic t_standby;
        drive(1, 0, 1, 1, 1, 19'h00077, '0);
        wait_cyc(2);
        chk("R4 op", 32'(bus_op), 32'd0);
        chk("R4 oe", 32'(dq_oe), 32'd0);
        drive(1, 1, 0, 1, 1, 19'h00077, 16'h1234);
        wait_cyc(2);
        chk("R9 standby beats write", 32'(bus_op), 32'd0);
    endtask

    task automatic t_write(input logic wide, input logic [AW-1:0] a, input logic [15:0] d);
        drive(0, 1, 1, 1, wide, a, '0);
        wait_cyc(1);
        drive(0, 1, 0, 1, wide, a, d);
        wait_cyc(2);
        chk("R5 write op", 32'(bus_op), 32'd3);
        chk("R5 write no drive", 32'(dq_oe), 32'd0);
        chk("R5 no early pulse", 32'(cmd_valid), 32'd0);
        drive(1, 1, 1, 1, wide, a, d);
        wait_cyc(1);
        chk("R5 pulse not yet", 32'(cmd_valid), 32'd0);
        wait_cyc(1);
        chk("R5 pulse", 32'(cmd_valid), 32'd1);
        chk("R5 addr", 32'(cmd_addr), 32'(a));
        if (wide) begin
            chk("R6 word data", 32'(cmd_data), 32'(d));
            chk("R6 word lane", 32'(cmd_lane), 32'd0);
        end else begin
            chk("R6 byte data", 32'(cmd_data), {24'h0, d[7:0]});
            chk("R6 byte lane", 32'(cmd_lane), 32'(d[15]));
        end
        wait_cyc(1);
        chk("R5 pulse ends", 32'(cmd_valid), 32'd0);
    endtask

    task automatic t_reset_pin;
        int cnt;
        drive(0, 1, 0, 1, 1, 19'h00456, 16'hBEEF);
        wait_cyc(3);
        drive(0, 1, 0, 0, 1, 19'h00456, 16'hBEEF);
        wait_cyc(2);
        chk("R7 op", 32'(bus_op), 32'd4);
        chk("R7 oe", 32'(dq_oe), 32'd0);
        drive(1, 1, 1, 1, 1, '0, '0);
        count_pulses(5, cnt);
        chk("R7 dropped write", 32'(cnt), 32'd0);
        drive(0, 0, 1, 0, 1, 19'h00222, '0);
        wait_cyc(3);
        chk("R8 read blocked", 32'(dq_oe), 32'd0);
        drive(0, 1, 0, 0, 1, 19'h00222, 16'h5555);
        wait_cyc(3);
        drive(1, 1, 1, 1, 1, '0, '0);
        count_pulses(5, cnt);
        chk("R8 write blocked", 32'(cnt), 32'd0);
    endtask

    task automatic t_conflict;
        int cnt;
        drive(0, 0, 0, 1, 1, 19'h00333, 16'hA5A5);
        wait_cyc(2);
        chk("R11 op", 32'(bus_op), 32'd1);
        chk("R11 oe", 32'(dq_oe), 32'd0);
        drive(1, 1, 1, 1, 1, '0, '0);
        count_pulses(5, cnt);
        chk("R11 no cmd", 32'(cnt), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_word_read(19'h0ABCD);
        t_word_read(19'h70F0F);
        t_byte_read(19'h01234, 1'b0);
        t_byte_read(19'h01234, 1'b1);
        t_out_off();
        t_standby();
        t_write(1'b1, 19'h05555, 16'h00AA);
        t_write(1'b0, 19'h02AAA, 16'h8055);
        t_write(1'b0, 19'h00AAA, 16'h0F3C);
        t_reset_pin();
        t_conflict();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule